// File: doc/BRIEF.md
# Fill-Word Elastic Buffer

This block carries a stream of 40-bit link words from the recovered receive clock into the local core clock. The two clocks are close in frequency but not identical. Each incoming word has already been aligned and decoded. A flag on each word tells the block whether it is an idle-type fill word or part of a frame. The words pass through a small dual-clock store. Its pointers cross between the domains in Gray code, through two-flop synchronisers.

The block absorbs the rate mismatch at the gaps between frames only. On the write side, it discards surplus fill words when the store runs too full. A gap always keeps its first three fill words, since a receiver needs three to see a gap. On the read side, it repeats the most recent fill word when the store runs too low. This happens only while a gap is being output. Frame words are never added, removed or reordered. When the compensation is not enough, a sticky error flag is raised: an overrun flag in the write domain and an underrun flag in the read domain.

After reset the read side waits until four words are stored before it emits its first word. From then on it produces one word per core clock cycle.

Top module: `fill_elastic_buf`

## Requirements
- R1: While reset is held, rd_valid, ovf_err and unf_err are 0.
- R2: Frame words (wr_fill=0) leave on rd_data in the order they arrived, with their data unchanged. No frame word is lost when neither error flag is set.
- R3: Between the last word of one frame and the first word of the next, the output carries at least 3 fill words.
- R4: An incoming fill word is discarded only when all three of these hold: the write-side occupancy is above 12 of the 16 entries, the word is a fill word, and at least 3 fill words of the current gap have already been stored. When the writer is faster than the reader, fewer fill words leave the block than entered it, and no error is flagged.
- R5: While a gap is being output and the read-side occupancy is below 4, the read side emits an extra fill word (rd_fill=1) equal to the previous output word, without consuming an entry. When the writer is slower than the reader, more fill words leave the block than entered it.
- R6: A word that arrives while the store holds 16 entries, and is not discarded under R4, is lost. ovf_err is then set to 1, and it stays 1 until wr_rst.
- R7: When the read side has no stored word and the last word output was a frame word, rd_valid is 0 for that cycle. unf_err is then set to 1, and it stays 1 until rd_rst.
- R8: A fill word keeps its 40-bit value through the block. Every fill word output in the gap after a frame carries a value written into that same gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | An incoming word is present this cycle |
| wr_fill | input | 1 | Incoming word is a fill word (1) or a frame word (0) |
| wr_data | input | 40 | Incoming decoded word |
| rd_clk | input | 1 | Local core clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| rd_fill | output | 1 | Output word is a fill word |
| rd_data | output | 40 | Output word |
| ovf_err | output | 1 | Sticky overrun flag (write domain) |
| unf_err | output | 1 | Sticky underrun flag (read domain) |

## Verification
The gap-length property assumes the incoming stream separates any two frames by at least three fill words. It also assumes that no fill word of a gap is lost to an overrun. The stimulus always precedes a frame with six or more fill words, and every frame it checks is sent without overrunning the store.

The repeat property assumes that both resets are held together at start-up, long enough for a few edges of each clock. The bench always asserts both resets for several cycles of the slower clock before releasing them. Overrun and underrun are provoked only in directed tests, where the gap property is no longer relied upon.

// File: rtl/feb_pkg.sv
package feb_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_POP    = 2'd1,
    ACT_INSERT = 2'd2,
    ACT_STARVE = 2'd3
  } rd_act_e;
endpackage

// File: rtl/feb_ptr_xfer.sv
module feb_ptr_xfer #(
  parameter int PW = 5
) (
  input  logic          src_clk,
  input  logic          src_rst,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] src_gray;
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) src_gray <= '0;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= src_gray;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign dst_bin[i] = ^sync_q[PW-1:i];
  end
endmodule

// File: rtl/feb_ram.sv
module feb_ram #(
  parameter int EW    = 41,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/feb_wr_ctrl.sv
module feb_wr_ctrl #(
  parameter int W       = 40,
  parameter int DEPTH   = 16,
  parameter int HI_WM   = 12,
  parameter int MIN_GAP = 3,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1,
  localparam int GW     = $clog2(MIN_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_fill,
  input  logic [W-1:0]  in_data,
  input  logic [PW-1:0] rd_ptr_sync,
  output logic [PW-1:0] wr_ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [W:0]    wdata,
  output logic          ovf_err
);
  logic [PW-1:0] occ;
  logic [GW-1:0] kept_q;
  logic          full;
  logic          drop_fill;

  assign occ       = wr_ptr - rd_ptr_sync;
  assign full      = (occ == PW'(DEPTH));
  assign drop_fill = in_valid && in_fill && (occ > PW'(HI_WM)) &&
                     (kept_q >= GW'(MIN_GAP));
  assign we        = in_valid && !drop_fill && !full;
  assign waddr     = wr_ptr[AW-1:0];
  assign wdata     = {in_fill, in_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      kept_q  <= '0;
      ovf_err <= 1'b0;
    end else begin
      if (we) wr_ptr <= wr_ptr + 1'b1;
      if (in_valid) begin
        if (!in_fill)
          kept_q <= '0;
        else if (we && kept_q < GW'(MIN_GAP))
          kept_q <= kept_q + 1'b1;
      end
      if (in_valid && !drop_fill && full) ovf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/feb_rd_ctrl.sv
module feb_rd_ctrl
  import feb_pkg::*;
#(
  parameter int W      = 40,
  parameter int DEPTH  = 16,
  parameter int LO_WM  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] wr_ptr_sync,
  input  logic [W:0]    rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rd_ptr,
  output logic          out_valid,
  output logic          out_fill,
  output logic [W-1:0]  out_data,
  output logic          ins_q,
  output logic          unf_err
);
  logic [PW-1:0] occ;
  logic          primed_q;
  logic          in_gap_q;
  rd_act_e       act;

  assign occ   = wr_ptr_sync - rd_ptr;
  assign raddr = rd_ptr[AW-1:0];

  always_comb begin
    if (!primed_q)
      act = (occ >= PW'(LO_WM)) ? ACT_POP : ACT_IDLE;
    else if (in_gap_q && occ < PW'(LO_WM))
      act = ACT_INSERT;
    else if (occ != '0)
      act = ACT_POP;
    else
      act = ACT_STARVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      primed_q  <= 1'b0;
      in_gap_q  <= 1'b0;
      out_valid <= 1'b0;
      out_fill  <= 1'b0;
      out_data  <= '0;
      ins_q     <= 1'b0;
      unf_err   <= 1'b0;
    end else begin
      ins_q <= (act == ACT_INSERT);
      case (act)
        ACT_POP: begin
          rd_ptr    <= rd_ptr + 1'b1;
          primed_q  <= 1'b1;
          in_gap_q  <= rdata[W];
          out_valid <= 1'b1;
          out_fill  <= rdata[W];
          out_data  <= rdata[W-1:0];
        end
        ACT_INSERT: begin
          out_valid <= 1'b1;
          out_fill  <= 1'b1;
        end
        ACT_STARVE: begin
          out_valid <= 1'b0;
          unf_err   <= 1'b1;
        end
        default: out_valid <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fill_elastic_buf.sv
module fill_elastic_buf #(
  parameter int W       = 40,
  parameter int DEPTH   = 16,
  parameter int LO_WM   = 4,
  parameter int HI_WM   = 12,
  parameter int MIN_GAP = 3
) (
  input  logic         wr_clk,
  input  logic         wr_rst,
  input  logic         wr_valid,
  input  logic         wr_fill,
  input  logic [W-1:0] wr_data,
  input  logic         rd_clk,
  input  logic         rd_rst,
  output logic         rd_valid,
  output logic         rd_fill,
  output logic [W-1:0] rd_data,
  output logic         ovf_err,
  output logic         unf_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, rd_ptr, wr_ptr_sync, rd_ptr_sync;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [W:0]    wdata, rdata;
  logic          rd_ins;

  feb_wr_ctrl #(.W(W), .DEPTH(DEPTH), .HI_WM(HI_WM), .MIN_GAP(MIN_GAP)) wr_ctrl_i (
    .clk(wr_clk), .rst(wr_rst), .in_valid(wr_valid), .in_fill(wr_fill),
    .in_data(wr_data), .rd_ptr_sync(rd_ptr_sync), .wr_ptr(wr_ptr),
    .we(we), .waddr(waddr), .wdata(wdata), .ovf_err(ovf_err)
  );

  feb_ram #(.EW(W + 1), .DEPTH(DEPTH)) ram_i (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  feb_ptr_xfer #(.PW(PW)) w2r_i (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_bin(wr_ptr),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_bin(wr_ptr_sync)
  );

  feb_ptr_xfer #(.PW(PW)) r2w_i (
    .src_clk(rd_clk), .src_rst(rd_rst), .src_bin(rd_ptr),
    .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_bin(rd_ptr_sync)
  );

  feb_rd_ctrl #(.W(W), .DEPTH(DEPTH), .LO_WM(LO_WM)) rd_ctrl_i (
    .clk(rd_clk), .rst(rd_rst), .wr_ptr_sync(wr_ptr_sync), .rdata(rdata),
    .raddr(raddr), .rd_ptr(rd_ptr), .out_valid(rd_valid), .out_fill(rd_fill),
    .out_data(rd_data), .ins_q(rd_ins), .unf_err(unf_err)
  );
endmodule

// File: rtl/feb_chk.sv
module feb_chk #(
  parameter int W       = 40,
  parameter int MIN_GAP = 3,
  localparam int CW     = $clog2(MIN_GAP + 1)
) (
  input logic         wr_clk,
  input logic         wr_rst,
  input logic         rd_clk,
  input logic         rd_rst,
  input logic         rd_valid,
  input logic         rd_fill,
  input logic [W-1:0] rd_data,
  input logic         rd_ins,
  input logic         ovf_err,
  input logic         unf_err
);
  logic [CW-1:0] run_q;
  logic          seen_frame_q;
  logic          prev_fill_q;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      run_q        <= '0;
      seen_frame_q <= 1'b0;
      prev_fill_q  <= 1'b0;
    end else if (rd_valid) begin
      if (rd_fill) begin
        if (run_q < CW'(MIN_GAP)) run_q <= run_q + 1'b1;
        prev_fill_q <= 1'b1;
      end else begin
        run_q        <= '0;
        prev_fill_q  <= 1'b0;
        seen_frame_q <= 1'b1;
      end
    end
  end

  AST_GAP_KEPT: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_valid && !rd_fill && seen_frame_q && prev_fill_q) |-> (run_q >= CW'(MIN_GAP))); // R3

  AST_INSERT_REPEATS: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ins |-> (rd_valid && rd_fill && $stable(rd_data))); // R5

  AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    ovf_err |=> ovf_err); // R6

  AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    unf_err |=> unf_err); // R7

  AST_STARVE_FLAGGED: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $fell(rd_valid) |-> unf_err); // R7
endmodule

bind fill_elastic_buf feb_chk #(.W(W), .MIN_GAP(MIN_GAP)) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .rd_clk(rd_clk), .rd_rst(rd_rst),
  .rd_valid(rd_valid), .rd_fill(rd_fill), .rd_data(rd_data),
  .rd_ins(rd_ins), .ovf_err(ovf_err), .unf_err(unf_err)
);

// File: tb/fill_elastic_buf_tb_top.sv
`timescale 1ns/100ps
module fill_elastic_buf_tb_top;
  localparam logic [39:0] FILL_IDLE = 40'hBC_95_B5_B5_B5;
  localparam logic [39:0] FILL_ARB  = 40'hBC_94_FF_FF_FF;

  typedef struct packed {
    int half_x10;
    int frames;
    int flen;
    int gap;
    int sign;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{95,  40, 16, 6, -1},
    '{105, 40, 16, 6,  1},
    '{100, 20, 12, 8,  0},
    '{95,  30,  8, 6, -1},
    '{105, 30, 20, 7,  1}
  };

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst = 1'b1, rd_rst = 1'b1;
  logic        wr_valid = 1'b1, wr_fill = 1'b1;
  logic [39:0] wr_data = FILL_IDLE;
  logic        rd_valid, rd_fill, ovf_err, unf_err;
  logic [39:0] rd_data;
  real         wr_half = 10.0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;

  bit mon_en = 0;
  int m_idx, m_run, m_fills, m_total, m_flen;
  bit m_prev_fill;

  fill_elastic_buf dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_fill(wr_fill),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid),
    .rd_fill(rd_fill), .rd_data(rd_data), .ovf_err(ovf_err), .unf_err(unf_err)
  );

  always #10 rd_clk = ~rd_clk;
  always #(wr_half) wr_clk = ~wr_clk;

  function automatic logic [39:0] frame_word(input int i);
    return {8'h3C, 32'(i)};
  endfunction

  function automatic logic [39:0] fill_val(input int g);
    return (g % 2 == 1) ? FILL_ARB : FILL_IDLE;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic f, input logic [39:0] d);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_fill  = f;
    wr_data  = d;
  endtask

  task automatic do_reset();
    mon_en = 0;
    wr_rst = 1'b1;
    rd_rst = 1'b1;
    wr_fill = 1'b1;
    wr_data = FILL_IDLE;
    repeat (5) @(negedge rd_clk);
    // R1: quiet outputs while reset is held
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(unf_err == 1'b0, "R1 unf_err", unf_err, 0);
    chk(ovf_err == 1'b0, "R1 ovf_err", ovf_err, 0);
    @(negedge wr_clk) wr_rst = 1'b0;
    @(negedge rd_clk) rd_rst = 1'b0;
  endtask

  // Output monitor: frame order (R2), gap length (R3), fill values (R8)
  always @(negedge rd_clk) begin
    if (mon_en && rd_valid) begin
      if (!rd_fill) begin
        if (m_idx > 0 && (m_idx % m_flen) == 0)
          chk(m_prev_fill && m_run >= 3, "R3 gap length", m_run, 3);
        chk(rd_data == frame_word(m_idx), "R2 frame word", rd_data, frame_word(m_idx));
        m_idx++;
        m_run = 0;
        m_prev_fill = 0;
      end else begin
        chk(rd_data == fill_val(m_idx / m_flen), "R8 fill value", rd_data,
            fill_val(m_idx / m_flen));
        m_run++;
        m_prev_fill = 1;
        if (m_idx > 0 && m_idx < m_total) m_fills++;
      end
    end
  end

  always @(posedge rd_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      wr_half = VECS[v].half_x10 / 10.0;
      do_reset();
      m_idx = 0; m_run = 0; m_fills = 0; m_prev_fill = 0;
      m_flen = VECS[v].flen;
      m_total = VECS[v].frames * VECS[v].flen;
      mon_en = 1;
      for (int f = 0; f < VECS[v].frames; f++) begin
        for (int g = 0; g < VECS[v].gap; g++) put(1'b1, fill_val(f));
        for (int k = 0; k < VECS[v].flen; k++) put(1'b0, frame_word(f * VECS[v].flen + k));
      end
      for (int k = 0; k < 400 && m_idx < m_total; k++) put(1'b1, fill_val(VECS[v].frames));
      repeat (4) put(1'b1, fill_val(VECS[v].frames));
      chk(m_idx == m_total, "R2 all frame words", m_idx, m_total);
      chk(ovf_err == 1'b0, "R6 no false overrun", ovf_err, 0);
      chk(unf_err == 1'b0, "R7 no false underrun", unf_err, 0);
      if (VECS[v].sign < 0)
        chk(m_fills < (VECS[v].frames - 1) * VECS[v].gap, "R4 fills deleted",
            m_fills, (VECS[v].frames - 1) * VECS[v].gap);
      else if (VECS[v].sign > 0)
        chk(m_fills > (VECS[v].frames - 1) * VECS[v].gap, "R5 fills inserted",
            m_fills, (VECS[v].frames - 1) * VECS[v].gap);
    end

    // R6: writer twice as fast with one long frame overruns the store
    wr_half = 5.0;
    do_reset();
    for (int g = 0; g < 6; g++) put(1'b1, FILL_IDLE);
    for (int k = 0; k < 40; k++) put(1'b0, frame_word(k));
    put(1'b1, FILL_IDLE);
    @(negedge wr_clk);
    chk(ovf_err == 1'b1, "R6 overrun flagged", ovf_err, 1);
    for (int g = 0; g < 30; g++) put(1'b1, FILL_IDLE);
    @(negedge wr_clk);
    chk(ovf_err == 1'b1, "R6 overrun sticky", ovf_err, 1);

    // R7: writer half as fast with one long frame underruns the store
    wr_half = 20.0;
    do_reset();
    for (int g = 0; g < 6; g++) put(1'b1, FILL_IDLE);
    for (int k = 0; k < 30; k++) put(1'b0, frame_word(k));
    put(1'b1, FILL_IDLE);
    @(negedge rd_clk);
    chk(unf_err == 1'b1, "R7 underrun flagged", unf_err, 1);
    chk(ovf_err == 1'b0, "R6 no overrun when slow", ovf_err, 0);
    for (int g = 0; g < 30; g++) put(1'b1, FILL_IDLE);
    @(negedge rd_clk);
    chk(unf_err == 1'b1, "R7 underrun sticky", unf_err, 1);

    // R1: reset clears the sticky flags
    do_reset();
    @(negedge rd_clk);
    chk(unf_err == 1'b0, "R1 unf cleared", unf_err, 0);
    chk(ovf_err == 1'b0, "R1 ovf cleared", ovf_err, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule